// File: doc/BRIEF.md
# DMA Request Sampler

This block watches an active-low DMA request line on behalf of a single-channel DMA engine and decides, cycle by cycle, when that engine may take the bus away from the CPU. Each request it accepts produces one bus-grant pair: one DMA read cycle, then one DMA write cycle. An acknowledge output covers both cycles, and a one-clock strobe marks each accepted request.

Two runtime selects set its behaviour. The transfer select picks cycle-steal, where the bus goes back to the CPU after every pair, or burst, where pairs keep running while the request stays active. The detection select picks level sensing, where a low line is a request, or falling-edge sensing, where the line must have been high in the previous cycle and low in the current one. The block checks the line at one fixed point. If it finds no request there, it keeps checking on every cycle until one appears. A transfer count is loaded during reset and counts down by one per pair. At zero the block stops granting and holds its done output high.

Top module: `dma_req_sampler`

## Requirements
- R1: With level detection (`edge_mode` = 0), a low `dreq_n` seen while the block is checking is taken as a request, and the DMA read cycle follows in the next clock.
- R2: When a check finds no request, the block checks `dreq_n` again on every following clock until it finds one, and it needs no other stimulus to do so.
- R3: With edge detection (`edge_mode` = 1), a request counts only if `dreq_n` was high in the previous clock and is low in the current clock. A line that stays low is not a request.
- R4: Each accepted request produces exactly one clock of `bus_rd`, followed at once by exactly one clock of `bus_wr`.
- R5: In cycle-steal mode (`burst_mode` = 0), the CPU then owns the bus for at least CPU_CYCLES clocks and until `cpu_done` is high. The line is not examined during that time. The next check falls in the first clock after the CPU cycle ends.
- R6: In burst mode (`burst_mode` = 1), the line is also checked during each write cycle. If it shows a request, the next read cycle follows immediately, with no CPU clocks between the pairs.
- R7: `dack` is high exactly in the DMA read and write clocks and low in every other clock.
- R8: `accept` is a one-clock pulse that coincides with the first read clock of each accepted request.
- R9: `xfer_count` is loaded while `rst_n` is low and is decremented at the end of every write cycle. While the remaining count is zero, `done` is high and any request is ignored: no `dack`, no `accept`.
- R10: After reset the edge detector behaves as if the line had been low, so in edge mode a line that is held low since reset raises no request until it has first gone high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; loads the transfer count |
| dreq_n | input | 1 | DMA request line, active low |
| burst_mode | input | 1 | 1 = burst transfers, 0 = cycle-steal |
| edge_mode | input | 1 | 1 = falling-edge detection, 0 = level detection |
| cpu_done | input | 1 | The CPU bus cycle is complete |
| xfer_count | input | CNT_W | Number of read/write pairs, loaded during reset |
| dack | output | 1 | DMA acknowledge, high in read and write cycles |
| accept | output | 1 | One-clock pulse when a request is taken |
| bus_rd | output | 1 | DMA read cycle in progress |
| bus_wr | output | 1 | DMA write cycle in progress |
| done | output | 1 | Transfer count exhausted |

## Verification
The in-RTL assertions check the following on every cycle:
- a read is always followed by a write;
- a write is always preceded by a read;
- `accept` falls only on a read clock and never on two clocks in a row;
- the CPU phase never ends before its minimum length;
- once `done` is high it stays high, and no bus cycles occur while it is high.

The remaining behaviour can only be shown by bench scenarios:
- where the sampling points fall;
- edge qualification, including the low-since-reset case;
- back-to-back burst pairs;
- the dependence on `cpu_done`.

The bench covers these with a cycle-accurate reference model, using directed sequences and randomized line activity.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
   typedef enum logic [1:0] {
      PH_WATCH = 2'd0,
      PH_READ  = 2'd1,
      PH_WRITE = 2'd2,
      PH_CPU   = 2'd3
   } phase_t;
endpackage

// File: rtl/dmarq_detect.sv
module dmarq_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic dreq_n,
   input  logic edge_mode,
   output logic req
);
   // Previous line level; reset value low so no edge before the line rises (R10)
   logic prev_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_hi <= 1'b0;
      else        prev_hi <= dreq_n;
   end

   always_comb begin
      if (edge_mode) req = prev_hi & ~dreq_n;
      else           req = ~dreq_n;
   end

   a_r10_no_edge_from_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && $past(!rst_n)) |-> !req);
endmodule

// File: rtl/dmarq_cpu_timer.sv
module dmarq_cpu_timer #(
   parameter int CPU_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_cpu,
   output logic min_met
);
   localparam int TW = (CPU_CYCLES < 2) ? 1 : $clog2(CPU_CYCLES + 1);
   localparam logic [TW-1:0] LIM = TW'(CPU_CYCLES - 1);

   generate
      if (CPU_CYCLES < 1) begin : g_bad_len
         $error("dmarq_cpu_timer: CPU_CYCLES must be at least 1");
      end
   endgenerate

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !in_cpu) cnt <= '0;
      else if (cnt != LIM)   cnt <= cnt + 1'b1;
   end

   assign min_met = in_cpu && (cnt == LIM);
endmodule

// File: rtl/dmarq_counter.sv
module dmarq_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero,
   output logic             last
);
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("dmarq_counter: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] rem;

   always_ff @(posedge clk) begin
      if (!rst_n)                rem <= load_val;
      else if (dec && rem != '0) rem <= rem - 1'b1;
   end

   assign zero = (rem == '0);
   assign last = (rem == CNT_W'(1));

   a_r9_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      zero |=> zero);
endmodule

// File: rtl/dma_req_sampler.sv
module dma_req_sampler
   import dmarq_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int CPU_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dreq_n,
   input  logic             burst_mode,
   input  logic             edge_mode,
   input  logic             cpu_done,
   input  logic [CNT_W-1:0] xfer_count,
   output logic             dack,
   output logic             accept,
   output logic             bus_rd,
   output logic             bus_wr,
   output logic             done
);
   phase_t phase_q, phase_d;
   logic   req, take, dec, zero, last, min_met, accept_q;

   dmarq_detect u_detect (
      .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n),
      .edge_mode(edge_mode), .req(req)
   );

   dmarq_cpu_timer #(.CPU_CYCLES(CPU_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .in_cpu(phase_q == PH_CPU), .min_met(min_met)
   );

   dmarq_counter #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .load_val(xfer_count),
      .dec(dec), .zero(zero), .last(last)
   );

   always_comb begin
      phase_d = phase_q;
      take    = 1'b0;
      dec     = 1'b0;
      unique case (phase_q)
         PH_WATCH: if (req && !zero) begin
            phase_d = PH_READ;
            take    = 1'b1;
         end
         PH_READ:  phase_d = PH_WRITE;
         PH_WRITE: begin
            dec = 1'b1;
            if (last)                   phase_d = PH_WATCH;
            else if (burst_mode && req) begin
               phase_d = PH_READ;
               take    = 1'b1;
            end
            else                        phase_d = PH_CPU;
         end
         PH_CPU:   if (min_met && cpu_done) phase_d = PH_WATCH;
         default:  phase_d = PH_WATCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_WATCH;
         accept_q <= 1'b0;
      end else begin
         phase_q  <= phase_d;
         accept_q <= take;
      end
   end

   assign bus_rd = (phase_q == PH_READ);
   assign bus_wr = (phase_q == PH_WRITE);
   assign dack   = bus_rd | bus_wr;
   assign accept = accept_q;
   assign done   = zero;

   a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_wr);
   a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> $past(bus_rd));
   a_r8_accept_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> bus_rd);
   a_r8_accept_single: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept);
   a_r5_cpu_min_len: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CPU && !min_met) |=> (phase_q == PH_CPU));
   a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !dack);
endmodule

// File: tb/dma_req_sampler_test.sv
module dma_req_sampler_test;
   localparam int CNT_W = 8;
   localparam int CPU_CYCLES = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dreq_n = 1'b1, burst_mode = 1'b0, edge_mode = 1'b0, cpu_done = 1'b0;
   logic [CNT_W-1:0] xfer_count = '0;
   logic dack, accept, bus_rd, bus_wr, done;

   int checks = 0;
   int errors = 0;
   string tag = "R1";

   // reference model state: 0 watch, 1 read, 2 write, 3 cpu
   int m_ph, m_cc, m_rem;
   bit m_prev, m_acc;

   always #2 clk = ~clk;

   dma_req_sampler #(.CNT_W(CNT_W), .CPU_CYCLES(CPU_CYCLES)) uut (
      .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .burst_mode(burst_mode),
      .edge_mode(edge_mode), .cpu_done(cpu_done), .xfer_count(xfer_count),
      .dack(dack), .accept(accept), .bus_rd(bus_rd), .bus_wr(bus_wr), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req, tag, act, exp_v, $time);
      end
   endtask

   function automatic bit m_req(bit d);
      return edge_mode ? (m_prev && !d) : !d;
   endfunction

   function automatic void m_step(bit d, bit cd);
      bit r;
      r = m_req(d);
      m_acc = 1'b0;
      case (m_ph)
         0: if (r && m_rem != 0) begin m_ph = 1; m_acc = 1'b1; end
         1: m_ph = 2;
         2: begin
            m_rem = m_rem - 1;
            if (m_rem == 0) m_ph = 0;
            else if (burst_mode && r) begin m_ph = 1; m_acc = 1'b1; end
            else begin m_ph = 3; m_cc = 0; end
         end
         default: if (m_cc >= CPU_CYCLES - 1 && cd) m_ph = 0;
                  else if (m_cc < CPU_CYCLES - 1) m_cc = m_cc + 1;
      endcase
      m_prev = d;
   endfunction

   task automatic compare();
      chk(bus_rd == (m_ph == 1), "R4", bus_rd, m_ph == 1);
      chk(bus_wr == (m_ph == 2), "R4", bus_wr, m_ph == 2);
      chk(dack == (m_ph == 1 || m_ph == 2), "R7", dack, m_ph == 1 || m_ph == 2);
      chk(accept == m_acc, "R8", accept, m_acc);
      chk(done == (m_rem == 0), "R9", done, m_rem == 0);
   endtask

   task automatic do_reset(input bit b, input bit e, input int cnt, input bit d);
      rst_n = 1'b0; burst_mode = b; edge_mode = e;
      xfer_count = CNT_W'(cnt); dreq_n = d; cpu_done = 1'b0;
      repeat (2) @(negedge clk);
      m_ph = 0; m_cc = 0; m_rem = cnt; m_prev = 1'b0; m_acc = 1'b0;
      rst_n = 1'b1;
      tag = "R9";
      chk(dack == 1'b0 && accept == 1'b0, "R7", dack, 0);
      chk(done == (cnt == 0), "R9", done, cnt == 0);
   endtask

   task automatic cyc(input bit d, input bit cd);
      dreq_n = d; cpu_done = cd;
      m_step(d, cd);
      @(negedge clk);
      compare();
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int acc_n;
      void'($urandom(32'd2024));
      @(negedge clk);

      // R10 / R3: line low from reset gives no edge; high-then-low does
      do_reset(1'b0, 1'b1, 3, 1'b0);
      tag = "R10";
      for (int i = 0; i < 6; i++) begin
         cyc(1'b0, 1'b1);
         chk(dack == 1'b0, "R10", dack, 0);
      end
      tag = "R3";
      cyc(1'b1, 1'b1);
      cyc(1'b0, 1'b1);
      chk(accept == 1'b1 && bus_rd == 1'b1, "R3", accept, 1);
      for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1);
      chk(dack == 1'b0, "R3", dack, 0);

      // R1 / R5: level cycle-steal, request held low
      do_reset(1'b0, 1'b0, 2, 1'b0);
      tag = "R1";
      cyc(1'b0, 1'b1);
      chk(accept == 1'b1 && bus_rd == 1'b1, "R1", bus_rd, 1);
      cyc(1'b0, 1'b1);
      chk(bus_wr == 1'b1, "R4", bus_wr, 1);
      tag = "R5";
      cyc(1'b0, 1'b1);
      chk(dack == 1'b0, "R5", dack, 0);
      cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b1);
      chk(bus_rd == 1'b0, "R5", bus_rd, 0);
      cyc(1'b0, 1'b1);
      chk(bus_rd == 1'b1, "R5", bus_rd, 1);
      // R5: cpu_done withheld keeps the CPU phase
      do_reset(1'b0, 1'b0, 3, 1'b0);
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1);
      for (int i = 0; i < 5; i++) begin
         cyc(1'b0, 1'b0);
         chk(dack == 1'b0, "R5", dack, 0);
      end
      cyc(1'b0, 1'b1); cyc(1'b0, 1'b1);
      chk(bus_rd == 1'b1, "R5", bus_rd, 1);

      // R2: no request at first check, then per-cycle checks catch it
      do_reset(1'b0, 1'b0, 2, 1'b1);
      tag = "R2";
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1);
      cyc(1'b0, 1'b1);
      chk(accept == 1'b1, "R2", accept, 1);

      // R6 / R9: burst, level, held low, count 3
      do_reset(1'b1, 1'b0, 3, 1'b0);
      tag = "R6";
      acc_n = 0;
      for (int i = 0; i < 6; i++) begin
         cyc(1'b0, 1'b0);
         chk(dack == 1'b1, "R6", dack, 1);
         if (accept) acc_n++;
      end
      chk(acc_n == 3, "R6", acc_n, 3);
      tag = "R9";
      for (int i = 0; i < 4; i++) begin
         cyc(1'b0, 1'b1);
         chk(dack == 1'b0 && done == 1'b1, "R9", dack, 0);
      end
      // R9: zero count from reset ignores requests
      do_reset(1'b0, 1'b0, 0, 1'b0);
      for (int i = 0; i < 4; i++) begin
         cyc(1'b0, 1'b1);
         chk(accept == 1'b0, "R9", accept, 0);
      end

      // randomized line activity against the reference model
      tag = "R2";
      for (int s = 0; s < 12; s++) begin
         do_reset(1'($urandom % 2), 1'($urandom % 2), int'($urandom % 7), 1'b1);
         tag = "R2";
         for (int i = 0; i < 300; i++)
            cyc(1'(($urandom % 3) != 0), 1'(($urandom % 2) == 0));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule